// File: doc/BRIEF.md
# Annunciator and LED Port Controller

This block is a small write-only register file with its output stage, meant for a segment LCD controller. It drives twelve annunciator segment enables, three LED pins and three general-purpose output pins. A write channel delivers a 4-bit address and an 8-bit data byte. Three addresses each hold on/off and blink settings for a group of four segments, and a fourth address holds the LED and port bits.

A per-frame strobe advances a shared 6-bit frame counter. Any segment whose blink enable is set is masked dark while the counter's top bit is 1. Segments therefore blink with 32 frames on and 32 frames off, and all blinking segments stay in phase. LED pins are active-low and port pins are active-high.

The write channel is a valid/ready stream. `wr_ready` is held high whenever the block is out of reset, so it never applies back-pressure. A beat transfers on any rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_addr` and `wr_data` are only sampled on such an edge.

Top module: `annun_led_ctrl`

## Requirements
- R1: While `rst_n` is low, all registers and the frame counter clear. This leaves every `aseg` bit at 0, `led_n` at all ones and `port_out` at all zeros.
- R2: Address 0 controls segments 1 to 4, address 1 controls segments 5 to 8, and address 2 controls segments 9 to 12. Segment n appears on `aseg[n-1]`. Within a group byte, the k-th segment (k = 0..3) takes its blink enable from bit 7-2k and its data bit from bit 6-2k.
- R3: A segment whose data bit is 0 is dark (0). A segment whose data bit is 1 and whose blink enable is 0 is lit (1) in every frame.
- R4: A segment whose data bit and blink enable are both 1 is lit while frame-counter bit 5 is 0 and dark while that bit is 1. This gives 32 frames on and 32 frames off.
- R5: The frame counter is 6 bits wide. It advances by one on each clock edge where `frame_tick` is high, wraps from 63 to 0, and otherwise holds its value.
- R6: Address 3 bits 2:0 store LED0 to LED2. Each `led_n[i]` drives the inverse of its stored bit.
- R7: Address 3 bits 5:3 store PORT0 to PORT2. Each `port_out[i]` drives its stored bit unchanged.
- R8: At address 3, bits 7 and 6 have no effect on any output.
- R9: A transfer to an address from 4 to 15 changes no output.
- R10: `wr_ready` is 1 out of reset. A transfer shows on the outputs right after the clock edge that accepts it. A cycle with `wr_valid` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always 1 out of reset) |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register data |
| frame_tick | input | 1 | One-cycle strobe per display frame |
| aseg | output | 12 | Annunciator segment enables, bit n-1 is segment n |
| led_n | output | 3 | LED pins, active-low |
| port_out | output | 3 | General output pins, active-high |

## Verification
Single-segment byte patterns (0x40, 0x10, 0x04, 0x01), written to each group address, tell apart a swapped group, a reversed bit-pair order and a swapped data/blink bit.

Mixed patterns with blink set are run while `frame_tick` pulses for more than 64 frames. These check that only the segments with both bits set go dark during the off half, and that the counter wraps back to the on half.

Alternating and all-ones bytes at address 3 separate the inverted LED group from the direct port group and show that the top two bits do nothing. Writes to high addresses and data presented with `wr_valid` low must leave every pin unchanged.

// File: rtl/annun_pkg.sv
package annun_pkg;
  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 8;
  localparam int GROUPS       = 3;
  localparam int SEGS_PER_GRP = 4;
  localparam int NUM_LED      = 3;
  localparam int NUM_PORT     = 3;
  localparam int FRAME_CNT_W  = 6;
  localparam int NUM_SEG      = GROUPS * SEGS_PER_GRP;
endpackage

// File: rtl/annun_regfile.sv
module annun_regfile #(
  parameter int ADDR_W   = annun_pkg::ADDR_W,
  parameter int DATA_W   = annun_pkg::DATA_W,
  parameter int GROUPS   = annun_pkg::GROUPS,
  parameter int NUM_LED  = annun_pkg::NUM_LED,
  parameter int NUM_PORT = annun_pkg::NUM_PORT
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [GROUPS-1:0][DATA_W-1:0] grp_q,
  output logic [NUM_LED-1:0]            led_q,
  output logic [NUM_PORT-1:0]           port_q
);
  localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(GROUPS);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        grp_q[g] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)
        grp_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q  <= '0;
      port_q <= '0;
    end else if (wr_en && wr_addr == PIN_ADDR) begin
      led_q  <= wr_data[NUM_LED-1:0];
      port_q <= wr_data[NUM_LED +: NUM_PORT];
    end
  end

  AST_HIGH_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > PIN_ADDR) |=> ($stable(grp_q) && $stable(led_q) && $stable(port_q))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $past(rst_n)) |=> ($stable(grp_q) && $stable(led_q) && $stable(port_q))); // R10
endmodule

// File: rtl/annun_blink_timer.sv
module annun_blink_timer #(
  parameter int CNT_W = annun_pkg::FRAME_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  output logic dark_half
);
  logic [CNT_W-1:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_cnt <= '0;
    else if (frame_tick)
      frame_cnt <= frame_cnt + 1'b1;
  end

  assign dark_half = frame_cnt[CNT_W-1];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1)); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && $past(rst_n)) |=> $stable(frame_cnt)); // R5
endmodule

// File: rtl/annun_seg_stage.sv
module annun_seg_stage #(
  parameter int DATA_W       = annun_pkg::DATA_W,
  parameter int GROUPS       = annun_pkg::GROUPS,
  parameter int SEGS_PER_GRP = annun_pkg::SEGS_PER_GRP
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [GROUPS-1:0][DATA_W-1:0]      grp_q,
  input  logic                               dark_half,
  output logic [GROUPS*SEGS_PER_GRP-1:0]     seg
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < SEGS_PER_GRP; k++) begin : g_seg
      localparam int DBIT = DATA_W - 2 - 2 * k;
      localparam int BBIT = DATA_W - 1 - 2 * k;
      logic on_bit, blink_en;
      assign on_bit   = grp_q[g][DBIT];
      assign blink_en = grp_q[g][BBIT];
      assign seg[g*SEGS_PER_GRP + k] = on_bit & ~(blink_en & dark_half);

      AST_STEADY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (on_bit && !blink_en) |-> seg[g*SEGS_PER_GRP + k]); // R3
    end
  end

  AST_DARK_HALF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_half && grp_q[0][DATA_W-1]) |-> !seg[0]); // R4
endmodule

// File: rtl/annun_led_ctrl.sv
module annun_led_ctrl #(
  parameter int ADDR_W       = annun_pkg::ADDR_W,
  parameter int DATA_W       = annun_pkg::DATA_W,
  parameter int GROUPS       = annun_pkg::GROUPS,
  parameter int SEGS_PER_GRP = annun_pkg::SEGS_PER_GRP,
  parameter int NUM_LED      = annun_pkg::NUM_LED,
  parameter int NUM_PORT     = annun_pkg::NUM_PORT,
  parameter int CNT_W        = annun_pkg::FRAME_CNT_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           frame_tick,
  output logic [GROUPS*SEGS_PER_GRP-1:0] aseg,
  output logic [NUM_LED-1:0]             led_n,
  output logic [NUM_PORT-1:0]            port_out
);
  localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(GROUPS);

  logic                          wr_en;
  logic [GROUPS-1:0][DATA_W-1:0] grp_q;
  logic [NUM_LED-1:0]            led_q;
  logic [NUM_PORT-1:0]           port_q;
  logic                          dark_half;

  assign wr_ready = rst_n;
  assign wr_en    = wr_valid & wr_ready;

  annun_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUPS(GROUPS),
    .NUM_LED(NUM_LED), .NUM_PORT(NUM_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .grp_q(grp_q), .led_q(led_q), .port_q(port_q)
  );

  annun_blink_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .dark_half(dark_half)
  );

  annun_seg_stage #(
    .DATA_W(DATA_W), .GROUPS(GROUPS), .SEGS_PER_GRP(SEGS_PER_GRP)
  ) u_segs (
    .clk(clk), .rst_n(rst_n), .grp_q(grp_q), .dark_half(dark_half), .seg(aseg)
  );

  assign led_n    = ~led_q;
  assign port_out = port_q;

  AST_LED_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PIN_ADDR) |=> led_n == ~$past(wr_data[NUM_LED-1:0])); // R6

  AST_PORT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PIN_ADDR) |=> port_out == $past(wr_data[NUM_LED +: NUM_PORT])); // R7

  AST_GROUP0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && wr_data == '0) |=> aseg[SEGS_PER_GRP-1:0] == '0); // R3

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R10

  AST_RESET_PINS: assert property (@(posedge clk)
    $past(!rst_n) |-> (aseg == '0 && led_n == '1 && port_out == '0)); // R1
endmodule

// File: tb/sim_annun_led_ctrl.sv
module sim_annun_led_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        frame_tick = 1'b0;
  logic [11:0] aseg;
  logic [2:0]  led_n;
  logic [2:0]  port_out;

  always #5 clk = ~clk;

  annun_led_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_tick(frame_tick),
    .aseg(aseg), .led_n(led_n), .port_out(port_out)
  );

  int errors = 0;
  int checks = 0;
  bit compare_on = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_grp[3] = '{0, 0, 0};
  int m_pins = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_grp = '{0, 0, 0}; m_pins = 0;
    end else begin
      if (wr_valid) begin
        if (wr_addr < 3) m_grp[wr_addr] = wr_data;
        else if (wr_addr == 3) m_pins = wr_data & 8'h3F;
      end
      if (frame_tick) m_cnt = (m_cnt + 1) % 64;
    end
  end

  function automatic logic [11:0] exp_seg();
    logic [11:0] r;
    for (int n = 0; n < 12; n++) begin
      int g = n / 4;
      int k = n % 4;
      bit d = m_grp[g][6 - 2*k];
      bit b = m_grp[g][7 - 2*k];
      r[n] = d && !(b && m_cnt >= 32);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !done) begin
      check(aseg == exp_seg(), "R2 R3 R4 segment outputs", aseg, exp_seg());
      check(led_n == ~m_pins[2:0], "R6 R8 led pins", led_n, 3'(~m_pins[2:0]));
      check(port_out == m_pins[5:3], "R7 R8 port pins", port_out, m_pins[5:3]);
    end
  end

  task automatic wr(input int a, input int d);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1;
      @(negedge clk);
    end
    frame_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(aseg == 12'h000, "R1 reset aseg", aseg, 0);
    check(led_n == 3'b111, "R1 reset led_n", led_n, 7);
    check(port_out == 3'b000, "R1 reset port_out", port_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_on = 1;
    check(wr_ready == 1'b1, "R10 ready high", wr_ready, 1);

    // R2 single segment walk, every group
    for (int g = 0; g < 3; g++) begin
      foreach (m_grp[i]) ; // keep loop body simple
      wr(g, 8'h40); wr(g, 8'h10); wr(g, 8'h04); wr(g, 8'h01);
      wr(g, 8'h80); wr(g, 8'h00);
    end
    wr(0, 8'h40);
    check(aseg == 12'h001, "R2 seg1 from addr0 bit6", aseg, 1);
    wr(2, 8'h01);
    check(aseg == 12'h801, "R2 seg12 from addr2 bit0", aseg, 12'h801);

    // R10 data presented without valid is ignored
    wr_addr = 4'd1; wr_data = 8'h55;
    @(negedge clk); @(negedge clk);
    check(aseg == 12'h801, "R10 no transfer without valid", aseg, 12'h801);

    // R3/R4 mixed blink and steady
    wr(0, 8'hC4);   // seg1 blink+on, seg3 steady on
    wr(1, 8'hFF);   // all blink
    wr(2, 8'h55);   // all steady on
    ticks(31);
    check(aseg[0] == 1'b1, "R4 frame 31 still lit", aseg[0], 1);
    ticks(1);
    check(aseg[0] == 1'b0, "R4 frame 32 dark", aseg[0], 0);
    check(aseg[2] == 1'b1, "R3 steady segment in dark half", aseg[2], 1);
    ticks(31);
    check(aseg[7:4] == 4'h0, "R4 blinking group dark at 63", aseg[7:4], 0);
    ticks(1);
    check(aseg[7:4] == 4'hF, "R5 wrap to on half", aseg[7:4], 4'hF);
    ticks(40);
    // R5 counter holds without tick
    repeat (5) @(negedge clk);
    check(aseg[0] == 1'b0, "R5 hold in dark half", aseg[0], 0);
    ticks(30);

    // R6 R7 R8 pin register
    wr(3, 8'h2A);
    check(led_n == 3'b101 && port_out == 3'b101, "R6 R7 pattern 2A",
          {led_n, port_out}, 6'b101101);
    wr(3, 8'hC0);
    check(led_n == 3'b111 && port_out == 3'b000, "R8 top bits ignored",
          {led_n, port_out}, 6'b111000);
    wr(3, 8'hFF);
    wr(3, 8'h15);

    // R9 high addresses ignored
    for (int a = 4; a < 16; a++) wr(a, 8'hFF);
    check(led_n == 3'b010 && port_out == 3'b010, "R9 pins after high-address writes",
          {led_n, port_out}, 6'b010010);

    // reset mid-run
    rst_n = 1'b0;
    compare_on = 0;
    @(negedge clk);
    check(aseg == 12'h000 && led_n == 3'b111 && port_out == 3'b000,
          "R1 reset after activity", {aseg, led_n, port_out}, 18'h00038);
    rst_n = 1'b1;
    @(negedge clk);
    compare_on = 1;
    ticks(3);
    @(negedge clk);
    finish_run();
  end
endmodule